// File: doc/BRIEF.md
# SAR ADC conversion controller

This block is the digital sequencer of a successive-approximation converter built on a charge-redistribution DAC. While idle it holds the input sampling switches closed so the capacitor arrays track the analog input. A falling edge on the active-low start pin ends acquisition. The controller then opens the sampling switches for one cycle and runs a binary search. It drives one trial bit at a time onto the DAC switch lines, most significant first. At the end of each bit period it samples the comparator and keeps or drops that bit.

When the last bit is decided, the busy flag drops and the code appears on the result port. The result is shown in straight binary or in twos complement, depending on a select pin. Two mode pins choose among four speed and power modes. The mode sets the clocks spent on each bit. In the two fast modes, a result that follows a long idle gap is marked stale. In the low-power mode, a power-down request is raised between conversions.

The analog array, comparator and reference lie outside the block. The comparator output is treated as high when the sampled input is at or above the level of the current trial code.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A high-to-low transition of `conv_n`, seen while `busy` is low, starts a conversion. `busy` goes high on the next clock edge and stays high for exactly 1 + WIDTH × (cycles per bit) clock cycles.
- R2: During the first busy cycle `sample_sw` is low and `trial` is all zero. Whenever `busy` is low, `sample_sw` is high and `trial` is all zero.
- R3: Trials run from bit WIDTH-1 down to bit 0. Each trial shows the bits already kept plus the bit under test. A bit is kept when `cmp_in` is high in the last cycle of its period. With an ideal comparator, the result equals the analog code.
- R4: The cycles per bit come from the mode latched at the start edge. The mode is {`mode_fast`,`mode_pulse`}: 2'b11 uses CPB_WIDE, 2'b10 uses CPB_FAST, 2'b00 uses CPB_NORM and 2'b01 uses CPB_PULSE.
- R5: With `twos_sel` low, `result` is the straight-binary code. With `twos_sel` high, `result` is that code with bit WIDTH-1 inverted, so midscale 2^(WIDTH-1) reads as 0. The select acts at once on a held result.
- R6: An input above full scale gives all ones in straight binary. An input below zero gives all zeros.
- R7: In modes 2'b1x, `stale` is set when a conversion completes if at least IDLE_LIMIT idle cycles went by since the previous completion (or since reset) before its start edge; otherwise it is cleared. In modes 2'b0x it is always cleared on completion.
- R8: In mode 2'b01, `pwr_dn` rises together with the fall of `busy` and drops when `busy` rises. In other modes it stays low.
- R9: A start edge arriving while `busy` is high is ignored. It neither lengthens the conversion nor starts a new one afterwards.
- R10: Synchronous active-high `rst` gives `busy` low, `stale` high, `pwr_dn` low, `sample_sw` high and `trial` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_n | input | 1 | Active-low convert start; the falling edge starts a conversion |
| mode_fast | input | 1 | Mode pin, upper bit of the mode |
| mode_pulse | input | 1 | Mode pin, lower bit of the mode |
| twos_sel | input | 1 | 1 selects twos-complement output coding |
| cmp_in | input | 1 | Comparator decision for the current trial |
| sample_sw | output | 1 | 1 closes the input sampling switches |
| trial | output | WIDTH | DAC switch pattern for the current trial |
| busy | output | 1 | High while a conversion runs |
| result | output | WIDTH | Last conversion result in the selected coding |
| stale | output | 1 | Last result follows an over-long idle gap |
| pwr_dn | output | 1 | Analog power-down request |

## Verification
The assertions check the following on every cycle:
- sampling switches and trial pattern are quiet while idle, and open with an empty trial on the first busy cycle;
- the power-down request drops as a conversion starts;
- the held result stays fixed between conversions;
- a stale result only follows a conversion started in a fast mode.

The bench's scenarios show the rest:
- the exact conversion length in each mode;
- the binary-search result across every in-range code and beyond both ends;
- both output codings;
- the stale flag after a long idle gap against a short one;
- a start edge that arrives mid-conversion and must leave no trace.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [1:0] {
        MODE_NORM  = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_FAST  = 2'b10,
        MODE_WIDE  = 2'b11
    } mode_t;

    typedef enum logic [1:0] {
        ST_ACQ,
        ST_OPEN,
        ST_TRIAL
    } state_t;

    function automatic logic mode_is_fast(input mode_t m);
        return m[1];
    endfunction

endpackage

// File: rtl/sar_bit_timer.sv
module sar_bit_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          bit_end
);
    logic [CW-1:0] cnt;

    assign bit_end = run && (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || bit_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/sar_idle_mon.sv
module sar_idle_mon #(
    parameter int IDLE_LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic idle,
    input  logic clear,
    output logic long_gap
);
    localparam int IW = $clog2(IDLE_LIMIT + 1);
    localparam logic [IW-1:0] LIM = IW'(IDLE_LIMIT);

    logic [IW-1:0] cnt;

    assign long_gap = (cnt >= LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= LIM;
        end else if (clear) begin
            cnt <= '0;
        end else if (idle && !long_gap) begin
            cnt <= cnt + IW'(1);
        end
    end

endmodule

// File: rtl/sar_fmt.sv
module sar_fmt #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             twos,
    output logic [WIDTH-1:0] code
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == WIDTH - 1) begin : g_msb
            assign code[i] = raw[i] ^ twos;
        end else begin : g_low
            assign code[i] = raw[i];
        end
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int CPB_WIDE   = 2,
    parameter int CPB_FAST   = 2,
    parameter int CPB_NORM   = 3,
    parameter int CPB_PULSE  = 4,
    parameter int IDLE_LIMIT = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_n,
    input  logic             mode_fast,
    input  logic             mode_pulse,
    input  logic             twos_sel,
    input  logic             cmp_in,
    output logic             sample_sw,
    output logic [WIDTH-1:0] trial,
    output logic             busy,
    output logic [WIDTH-1:0] result,
    output logic             stale,
    output logic             pwr_dn
);
    localparam int IXW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int CPB_MAX = (CPB_WIDE > CPB_FAST ? CPB_WIDE : CPB_FAST) >
                             (CPB_NORM > CPB_PULSE ? CPB_NORM : CPB_PULSE) ?
                             (CPB_WIDE > CPB_FAST ? CPB_WIDE : CPB_FAST) :
                             (CPB_NORM > CPB_PULSE ? CPB_NORM : CPB_PULSE);
    localparam int CW = $clog2(CPB_MAX + 1);
    localparam int CPB_TAB [4] = '{CPB_NORM, CPB_PULSE, CPB_FAST, CPB_WIDE};

    state_t           state;
    mode_t            mode_q;
    logic             conv_q;
    logic             start;
    logic             long_gap;
    logic             bit_end;
    logic             stale_pend;
    logic [IXW-1:0]   idx;
    logic [WIDTH-1:0] kept;
    logic [WIDTH-1:0] res_raw;
    logic [CW-1:0]    cpb_sel;

    assign start     = conv_q && !conv_n && (state == ST_ACQ);
    assign cpb_sel   = CW'(CPB_TAB[mode_q]);
    assign sample_sw = (state == ST_ACQ);
    assign trial     = (state == ST_TRIAL) ? (kept | (WIDTH'(1) << idx)) : '0;

    sar_bit_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == ST_TRIAL),
        .limit   (cpb_sel),
        .bit_end (bit_end)
    );

    sar_idle_mon #(.IDLE_LIMIT(IDLE_LIMIT)) u_idle (
        .clk      (clk),
        .rst      (rst),
        .idle     (state == ST_ACQ),
        .clear    (start),
        .long_gap (long_gap)
    );

    sar_fmt #(.WIDTH(WIDTH)) u_fmt (
        .raw  (res_raw),
        .twos (twos_sel),
        .code (result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_ACQ;
            mode_q     <= MODE_NORM;
            conv_q     <= 1'b1;
            busy       <= 1'b0;
            stale      <= 1'b1;
            pwr_dn     <= 1'b0;
            stale_pend <= 1'b0;
            idx        <= '0;
            kept       <= '0;
            res_raw    <= '0;
        end else begin
            conv_q <= conv_n;
            case (state)
                ST_ACQ: begin
                    if (start) begin
                        state      <= ST_OPEN;
                        mode_q     <= mode_t'({mode_fast, mode_pulse});
                        busy       <= 1'b1;
                        pwr_dn     <= 1'b0;
                        stale_pend <= mode_fast && long_gap;
                        kept       <= '0;
                        idx        <= IXW'(WIDTH - 1);
                    end
                end
                ST_OPEN: begin
                    state <= ST_TRIAL;
                end
                default: begin
                    if (bit_end) begin
                        kept[idx] <= cmp_in;
                        if (idx == '0) begin
                            state   <= ST_ACQ;
                            busy    <= 1'b0;
                            res_raw <= {kept[WIDTH-1:1], cmp_in};
                            stale   <= stale_pend;
                            pwr_dn  <= (mode_q == MODE_PULSE);
                        end else begin
                            idx <= idx - IXW'(1);
                        end
                    end
                end
            endcase
        end
    end

    // R2: switches closed and trial pattern empty while idle
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sample_sw && trial == '0));

    // R2: first busy cycle opens the switches before any trial bit
    a_r2_open_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!sample_sw && trial == '0));

    // R8: power-down request released as a conversion begins
    a_r8_pd_release: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !pwr_dn);

    // R3: held result only changes when a conversion completes
    a_r3_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(res_raw));

    // R7: a stale mark only follows a conversion started in a fast mode
    a_r7_stale_fast: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && stale) |-> mode_is_fast(mode_q));

endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 8;
    localparam int LIMIT = 40;
    localparam int CPBS [4] = '{3, 4, 2, 2};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_n = 1'b1;
    logic         mode_fast = 1'b0;
    logic         mode_pulse = 1'b0;
    logic         twos_sel = 1'b0;
    logic         cmp_in;
    logic         sample_sw;
    logic [W-1:0] trial;
    logic         busy;
    logic [W-1:0] result;
    logic         stale;
    logic         pwr_dn;
    int           ain = 0;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign cmp_in = (ain >= int'(trial));

    sar_conv_ctrl #(
        .WIDTH(W), .CPB_WIDE(2), .CPB_FAST(2), .CPB_NORM(3), .CPB_PULSE(4),
        .IDLE_LIMIT(LIMIT)
    ) u0 (
        .clk(clk), .rst(rst), .conv_n(conv_n), .mode_fast(mode_fast),
        .mode_pulse(mode_pulse), .twos_sel(twos_sel), .cmp_in(cmp_in),
        .sample_sw(sample_sw), .trial(trial), .busy(busy), .result(result),
        .stale(stale), .pwr_dn(pwr_dn)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp(input int v);
        if (v < 0) return 0;
        if (v > (1 << W) - 1) return (1 << W) - 1;
        return v;
    endfunction

    // one conversion; checks length, first cycles, result, coding, pwr_dn
    task automatic convert(input int m, input int a, input bit retrig, input int exp_stale);
        int cnt = 0;
        int expv;
        mode_fast  = m[1];
        mode_pulse = m[0];
        ain        = a;
        expv       = clamp(a);
        @(negedge clk);
        conv_n = 1'b0;
        @(negedge clk);
        conv_n = 1'b1;
        while (busy) begin
            cnt++;
            if (cnt == 1) begin
                check(!sample_sw && trial == 0, "R2 open first", int'(trial), 0);
                check(!pwr_dn, "R8 pd released", int'(pwr_dn), 0);
            end
            if (cnt == 2)
                check(trial == W'(1 << (W - 1)), "R3 msb trial", int'(trial), 1 << (W - 1));
            if (retrig && cnt == 5) conv_n = 1'b0;
            if (retrig && cnt == 6) conv_n = 1'b1;
            @(negedge clk);
        end
        check(cnt == 1 + W * CPBS[m], "R1/R4 busy length", cnt, 1 + W * CPBS[m]);
        check(sample_sw && trial == 0, "R2 idle quiet", int'(trial), 0);
        twos_sel = 1'b0;
        #1;
        check(int'(result) == expv, "R3/R6 straight", int'(result), expv);
        twos_sel = 1'b1;
        #1;
        check(int'(result) == (expv ^ (1 << (W - 1))), "R5 twos", int'(result),
              expv ^ (1 << (W - 1)));
        twos_sel = 1'b0;
        check(pwr_dn == (m == 1), "R8 pd after", int'(pwr_dn), int'(m == 1));
        if (exp_stale >= 0)
            check(int'(stale) == exp_stale, "R7 stale", int'(stale), exp_stale);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy, "R10 busy", int'(busy), 0);
        check(stale, "R10 stale", int'(stale), 1);
        check(!pwr_dn, "R10 pwr_dn", int'(pwr_dn), 0);
        check(sample_sw && trial == 0, "R10 switches", int'(sample_sw), 1);
        rst = 1'b0;
        @(negedge clk);

        // R7: first fast conversion after reset counts as a long gap
        convert(2, 100, 1'b0, 1);
        convert(2, 101, 1'b0, 0);
        // R7: long gap in fast and wide modes, not in normal mode
        repeat (LIMIT + 10) @(negedge clk);
        convert(3, 7, 1'b0, 1);
        convert(3, 8, 1'b0, 0);
        repeat (LIMIT + 10) @(negedge clk);
        convert(0, 9, 1'b0, 0);
        repeat (LIMIT / 4) @(negedge clk);
        convert(2, 10, 1'b0, 0);

        // R9: start edge during busy is ignored
        convert(0, 77, 1'b1, 0);
        repeat (3) begin
            @(negedge clk);
            check(!busy, "R9 no restart", int'(busy), 0);
        end

        // R3 R4 R5 R6 sweep: every mode, every code and beyond both ends
        for (int m = 0; m < 4; m++) begin
            for (int a = -2; a <= (1 << W) + 1; a++) begin
                convert(m, a, 1'b0, 0);
            end
        end

        // R8: pwr_dn stays high between low-power conversions
        convert(1, 3, 1'b0, 0);
        repeat (5) @(negedge clk);
        check(pwr_dn, "R8 pd held", int'(pwr_dn), 1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule